// File: doc/BRIEF.md
# Audio Clock Supervisor with Soft-Start Mute

This block sits in front of a stereo audio DAC datapath and decides, cycle by cycle, whether the left and right samples may pass. It runs on a free-running reference clock. It brings the master clock, the frame (left/right) clock and the serial-clock mode select into that domain through synchronizers. For each frame it counts master-clock rising edges. A separate timer watches for the master clock stopping.

Any of four clock faults clears the gain to zero at once, and both channels then output code 0. Code 0 is the midscale of a signed sample, so a capacitively coupled load sees no step. The four faults are: a frame ratio outside the legal set, a switch between two legal ratios, a toggle of the mode select, and loss of the master clock. Once the ratio has been stable and legal for several frames and the master clock is present, the gain climbs linearly back to unity over the soft-start interval. A fault during the climb sends it back to zero.

Top module: `audio_clk_guard`

## Requirements
- R1: A frame ratio is accepted only after four consecutive frames measure the same legal ratio. The legal ratios are exactly 256, 384 and 512 master-clock rising edges per frame-clock period, counted from one frame-clock rising edge to the next. Until a ratio is accepted after reset, `mute` is 1 and both outputs are 0.
- R2: A frame whose measured ratio is not 256, 384 or 512 is a fault. A fault forces `mute` high and both outputs to 0.
- R3: A frame that measures a legal ratio different from the accepted one is a fault, and the accepted ratio is dropped.
- R4: Any change of level on `sclk_mode` is a fault and mutes the outputs within six reference cycles.
- R5: If no synchronized master-clock rising edge arrives for REF_HZ/MIN_MCLK_HZ reference cycles, the master clock counts as lost. This is a fault, and it persists until an edge returns.
- R6: While the gain is zero, both outputs are exactly 0, which is the midscale code of a signed sample.
- R7: The gain rises by one step per STEP reference cycles, from 0 up to unity (2^GAIN_W). Each output equals (sample × gain) arithmetically shifted right by GAIN_W, registered once. Output magnitude never exceeds input magnitude and never falls during a ramp. From the first nonzero output to the fall of `mute` is exactly (2^GAIN_W − 1) × STEP cycles. STEP is (REF_HZ/1000 × RAMP_MS) >> GAIN_W.
- R8: A fault during the ramp returns the gain to zero, so the outputs return to 0. The next ramp then runs its full length.
- R9: `mute` is high from the first fault until the gain reaches unity, and it falls in the same cycle that unity-gain samples first appear. While `mute` is low, each output equals its input one cycle earlier.
- R10: During and right after a synchronous reset, `mute` is 1 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Master clock, asynchronous to clk |
| lrclk | input | 1 | Frame (left/right) clock, asynchronous to clk |
| sclk_mode | input | 1 | Serial-clock mode select; any toggle is a fault |
| in_l | input | SAMPLE_W | Signed left sample |
| in_r | input | SAMPLE_W | Signed right sample |
| out_l | output | SAMPLE_W | Gain-scaled left sample, registered |
| out_r | output | SAMPLE_W | Gain-scaled right sample, registered |
| mute | output | 1 | High while muted or ramping |

## Verification
A lost fault shows at the ports as samples still passing at unity after the clocks have gone bad. The bench flags this once the latency bound for that fault has passed. A gain register that does not clear, or an accepted ratio that is not dropped, shows as nonzero output inside a hold window, or as a ramp whose measured length is not exactly 5100 cycles. The product or shift path can go wrong in ways a hold window would miss. Those errors show on the first unmuted cycle, as a mismatch between the output and the previous input.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam int MAX_RATIO = 512;
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  typedef enum logic [1:0] {
    RC_BAD = 2'd0,
    RC_256 = 2'd1,
    RC_384 = 2'd2,
    RC_512 = 2'd3
  } ratio_code_t;

  function automatic ratio_code_t classify(input logic [CNT_W-1:0] n);
    if (n == CNT_W'(256))      return RC_256;
    else if (n == CNT_W'(384)) return RC_384;
    else if (n == CNT_W'(512)) return RC_512;
    else                       return RC_BAD;
  endfunction
endpackage

// File: rtl/acm_sync.sv
module acm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/acm_clk_check.sv
module acm_clk_check
  import acm_pkg::*;
#(
  parameter int LOSS_LIMIT = 25000,
  parameter int AGREE      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_s,
  input  logic lr_s,
  input  logic mode_s,
  output logic fault,
  output logic valid
);
  localparam int LOSS_W = $clog2(LOSS_LIMIT + 1);
  localparam int AG_W   = $clog2(AGREE + 1);
  localparam logic [LOSS_W-1:0] LOSS_MAX = LOSS_W'(LOSS_LIMIT);

  logic              mclk_d, lr_d, mode_d;
  logic [CNT_W-1:0]  per_cnt;
  logic [LOSS_W-1:0] loss_cnt;
  logic [AG_W-1:0]   agree, agree_nxt;
  ratio_code_t       code, last_code, lock_code;
  logic              locked, mclk_rise, lr_rise, loss, overrun, bad_frame;

  always_comb begin
    mclk_rise = mclk_s & ~mclk_d;
    lr_rise   = lr_s & ~lr_d;
    code      = classify(per_cnt);
    loss      = (loss_cnt >= LOSS_MAX);
    overrun   = (per_cnt > CNT_W'(MAX_RATIO));
    bad_frame = lr_rise && ((code == RC_BAD) || (locked && code != lock_code));
    fault     = loss | overrun | bad_frame | (mode_s != mode_d);
    valid     = locked & ~loss;
    if (code == last_code)
      agree_nxt = (agree == AG_W'(AGREE)) ? agree : agree + 1'b1;
    else
      agree_nxt = AG_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_d    <= 1'b0;
      lr_d      <= 1'b0;
      mode_d    <= 1'b0;
      per_cnt   <= '0;
      loss_cnt  <= '0;
      agree     <= '0;
      locked    <= 1'b0;
      last_code <= RC_BAD;
      lock_code <= RC_BAD;
    end else begin
      mclk_d <= mclk_s;
      lr_d   <= lr_s;
      mode_d <= mode_s;

      if (mclk_rise)  loss_cnt <= '0;
      else if (!loss) loss_cnt <= loss_cnt + 1'b1;

      if (lr_rise)                           per_cnt <= CNT_W'(mclk_rise);
      else if (mclk_rise && per_cnt != '1)   per_cnt <= per_cnt + 1'b1;

      if (fault) begin
        locked    <= 1'b0;
        agree     <= '0;
        last_code <= RC_BAD;
      end else if (lr_rise) begin
        agree     <= agree_nxt;
        last_code <= code;
        if (agree_nxt == AG_W'(AGREE)) begin
          locked    <= 1'b1;
          lock_code <= code;
        end
      end
    end
  end
endmodule

// File: rtl/acm_soft_ramp.sv
module acm_soft_ramp #(
  parameter int GAIN_W      = 8,
  parameter int STEP_CYCLES = 3906
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fault,
  input  logic            valid,
  output logic [GAIN_W:0] gain,
  output logic            mute
);
  localparam int STEP_W = $clog2(STEP_CYCLES + 1);
  localparam logic [GAIN_W:0]   UNITY    = (GAIN_W+1)'(1) << GAIN_W;
  localparam logic [STEP_W-1:0] STEP_END = STEP_W'(STEP_CYCLES - 1);

  logic [STEP_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst || fault) begin
      gain <= '0;
      tmr  <= '0;
      mute <= 1'b1;
    end else if (valid && gain != UNITY) begin
      if (tmr == STEP_END) begin
        tmr  <= '0;
        gain <= gain + 1'b1;
        mute <= (gain + 1'b1) != UNITY;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_clk_guard.sv
module audio_clk_guard #(
  parameter int REF_HZ        = 50_000_000,
  parameter int MIN_MCLK_HZ   = 2000,
  parameter int RAMP_MS       = 20,
  parameter int GAIN_W        = 8,
  parameter int SAMPLE_W      = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int AGREE_PERIODS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mclk,
  input  logic                       lrclk,
  input  logic                       sclk_mode,
  input  logic signed [SAMPLE_W-1:0] in_l,
  input  logic signed [SAMPLE_W-1:0] in_r,
  output logic signed [SAMPLE_W-1:0] out_l,
  output logic signed [SAMPLE_W-1:0] out_r,
  output logic                       mute
);
  localparam int LOSS_LIMIT  = REF_HZ / MIN_MCLK_HZ;
  localparam int RAMP_CYCLES = (REF_HZ / 1000) * RAMP_MS;
  localparam int STEP_RAW    = RAMP_CYCLES >> GAIN_W;
  localparam int STEP_CYCLES = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam int NCH         = 2;
  localparam int PROD_W      = SAMPLE_W + GAIN_W + 2;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  logic            mclk_s, lr_s, mode_s, fault, valid, ramp_mute;
  logic [GAIN_W:0] gain;
  sample_t         smp_in  [NCH];
  sample_t         smp_out [NCH];

  acm_sync #(.STAGES(SYNC_STAGES)) u_sync_mclk (.clk(clk), .rst(rst), .d(mclk),      .q(mclk_s));
  acm_sync #(.STAGES(SYNC_STAGES)) u_sync_lr   (.clk(clk), .rst(rst), .d(lrclk),     .q(lr_s));
  acm_sync #(.STAGES(SYNC_STAGES)) u_sync_mode (.clk(clk), .rst(rst), .d(sclk_mode), .q(mode_s));

  acm_clk_check #(
    .LOSS_LIMIT(LOSS_LIMIT),
    .AGREE     (AGREE_PERIODS)
  ) u_check (
    .clk(clk), .rst(rst), .mclk_s(mclk_s), .lr_s(lr_s), .mode_s(mode_s),
    .fault(fault), .valid(valid)
  );

  acm_soft_ramp #(
    .GAIN_W     (GAIN_W),
    .STEP_CYCLES(STEP_CYCLES)
  ) u_ramp (
    .clk(clk), .rst(rst), .fault(fault), .valid(valid),
    .gain(gain), .mute(ramp_mute)
  );

  assign smp_in[0] = in_l;
  assign smp_in[1] = in_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic signed [PROD_W-1:0] prod;
    assign prod = smp_in[ch] * $signed({1'b0, gain});
    always_ff @(posedge clk) begin
      if (rst) smp_out[ch] <= '0;
      else     smp_out[ch] <= sample_t'(prod >>> GAIN_W);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mute <= 1'b1;
    else     mute <= ramp_mute;
  end

  assign out_l = smp_out[0];
  assign out_r = smp_out[1];
endmodule

// File: rtl/acm_guard_chk.sv
module acm_guard_chk #(
  parameter int GAIN_W   = 8,
  parameter int SAMPLE_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       fault,
  input logic [GAIN_W:0]            gain,
  input logic                       mute,
  input logic signed [SAMPLE_W-1:0] in_l,
  input logic signed [SAMPLE_W-1:0] in_r,
  input logic signed [SAMPLE_W-1:0] out_l,
  input logic signed [SAMPLE_W-1:0] out_r
);
  localparam logic [GAIN_W:0] UNITY = (GAIN_W+1)'(1) << GAIN_W;

  AST_PASS_WHEN_UNMUTED: assert property (@(posedge clk) disable iff (rst)
    !mute |-> (out_l == $past(in_l) && out_r == $past(in_r)));                 // R9
  AST_ZERO_AT_NO_GAIN: assert property (@(posedge clk) disable iff (rst)
    (gain == '0) |=> (out_l == '0 && out_r == '0));                            // R6
  AST_FAULT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    fault |=> (gain == '0));                                                   // R8
  AST_FAULT_MUTES: assert property (@(posedge clk) disable iff (rst)
    fault |=> ##1 mute);                                                       // R2
  AST_GAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (gain != $past(gain)) |-> (gain == '0 || gain == $past(gain) + 1'b1));     // R7
  AST_GAIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    gain <= UNITY);                                                            // R7
  AST_UNMUTE_AT_UNITY: assert property (@(posedge clk) disable iff (rst)
    $fell(mute) |-> ($past(gain) == UNITY));                                   // R9
endmodule

bind audio_clk_guard acm_guard_chk #(
  .GAIN_W  (GAIN_W),
  .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk(clk), .rst(rst), .fault(fault), .gain(gain), .mute(mute),
  .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r)
);

// File: tb/audio_clk_guard_tb.sv
module audio_clk_guard_tb;
  localparam int SW       = 16;
  localparam int LOSS     = 128;       // 256000 / 2000
  localparam int RAMP_LEN = 255 * 20;  // (2^8 - 1) * STEP, STEP = 5120 >> 8
  localparam int LRP      = 1024;      // ref cycles per 256-ratio frame, mclk = 4 ref cycles
  localparam int M_SKIP = 0, M_HOLD = 1, M_RAMP = 2, M_RUN = 3;

  logic clk = 1'b0, rst = 1'b1, mclk = 1'b0, lrclk = 1'b0, sclk_mode = 1'b0;
  logic signed [SW-1:0] in_l = 16'sd20000, in_r = -16'sd20000;
  logic signed [SW-1:0] out_l, out_r;
  logic mute;

  audio_clk_guard #(.REF_HZ(256_000), .MIN_MCLK_HZ(2000), .RAMP_MS(20), .GAIN_W(8), .SAMPLE_W(SW))
    u_dut (.clk(clk), .rst(rst), .mclk(mclk), .lrclk(lrclk), .sclk_mode(sclk_mode),
           .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r), .mute(mute));

  always #10 clk = ~clk;

  // clock pattern generator
  bit gen_on = 1'b1;
  int cur_ratio = 256, next_ratio = 256, ph = 0, rises = 0;
  always @(negedge clk) begin
    if (gen_on) begin
      ph = ph + 1;
      if (ph == 2) begin
        ph = 0;
        mclk = ~mclk;
        if (mclk) begin
          rises = rises + 1;
          if (rises >= cur_ratio / 2) begin
            rises = 0;
            lrclk = ~lrclk;
            if (lrclk) cur_ratio = next_ratio;
          end
        end
      end
    end
  end

  int vectors = 0, fails = 0, cyc = 0, mode = M_HOLD;
  bit armed = 1'b0, restart_armed = 1'b0, restart_seen = 1'b0, done = 1'b0;
  int arm_t = 0, arm_bound = 0, first_nz = -1, prev_abs = 0, ramp_len = -1, ramps = 0;
  string arm_req = "";

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // per-clock behavioural model comparison
  always @(posedge clk) begin
    #2;
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
      finish_run();
    end
    case (mode)
      M_HOLD: begin  // R6 R10
        chk(mute == 1'b1, "R6", "mute in hold", int'(mute), 1);
        chk(out_l == 0 && out_r == 0, "R6", "midscale in hold", int'(out_l), 0);
      end
      M_RAMP: begin
        if (!mute) begin
          ramp_len = cyc - first_nz;
          ramps++;
          chk(ramp_len == RAMP_LEN, "R7", "ramp length", ramp_len, RAMP_LEN);
          chk(out_l == in_l && out_r == in_r, "R9", "unity at unmute", int'(out_l), int'(in_l));
          mode = M_RUN;
        end else begin
          chk(iabs(int'(out_l)) <= iabs(int'(in_l)), "R7", "ramp magnitude", int'(out_l), int'(in_l));
          if (out_l != 0) begin
            if (first_nz < 0) first_nz = cyc;
            chk(iabs(int'(out_l)) >= prev_abs, "R7", "ramp monotonic", iabs(int'(out_l)), prev_abs);
          end else if (prev_abs != 0) begin
            if (restart_armed) begin
              restart_armed = 1'b0;
              restart_seen  = 1'b1;
              first_nz      = -1;
            end else begin
              chk(1'b0, "R8", "unexpected ramp drop", 0, prev_abs);
            end
          end
          prev_abs = iabs(int'(out_l));
        end
      end
      M_RUN: begin
        if (mute) begin
          chk(armed, "R9", "mute without fault", int'(mute), 0);
          if (armed)
            chk(cyc - arm_t <= arm_bound, arm_req, "fault latency", cyc - arm_t, arm_bound);
          chk(out_l == 0 && out_r == 0, "R9", "zero at mute rise", int'(out_l), 0);
          armed = 1'b0;
          mode  = M_HOLD;
        end else begin
          chk(out_l == in_l && out_r == in_r, "R9", "passthrough", int'(out_l), int'(in_l));
        end
      end
      default: ;
    endcase
  end

  task automatic wait_mode(input int m, input int lim, input string req);
    int n = 0;
    while (mode != m && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(mode == m, req, "reached model state", mode, m);
  endtask

  task automatic arm(input string req, input int bound);
    arm_req   = req;
    arm_bound = bound;
    arm_t     = cyc;
    armed     = 1'b1;
  endtask

  task automatic hold_then_ramp(input int hold, input string req);
    repeat (hold) @(negedge clk);
    first_nz = -1;
    prev_abs = 0;
    mode     = M_RAMP;
    wait_mode(M_RUN, 6 * 1536 + RAMP_LEN + 200, req);
  endtask

  task automatic run_traffic();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      in_l = 16'(i * 211 - 31000);
      in_r = 16'(29000 - i * 173);
    end
    @(negedge clk);
    in_l = 16'sd20000;
    in_r = -16'sd20000;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int t0;
    repeat (5) @(negedge clk);
    chk(mute == 1'b1 && out_l == 0, "R10", "reset state", int'(mute), 1);
    rst = 1'b0;
    t0 = cyc;
    // R1: startup lock needs four agreeing legal frames
    hold_then_ramp(2 * LRP, "R1");
    chk(first_nz - t0 >= 3 * LRP, "R1", "no gain before 4 frames", first_nz - t0, 3 * LRP);
    run_traffic();

    // R3: switch 256 -> 384
    @(negedge clk); arm("R3", 2 * 1536 + 40); next_ratio = 384;
    wait_mode(M_HOLD, 4000, "R3");
    hold_then_ramp(2 * 1536, "R3");
    run_traffic();

    // R2: illegal ratio 300, then back to 256
    @(negedge clk); arm("R2", 2 * 1536 + 40); next_ratio = 300;
    wait_mode(M_HOLD, 4000, "R2");
    next_ratio = 256;
    hold_then_ramp(2 * LRP, "R2");
    run_traffic();

    // R4: mode select toggle
    @(negedge clk); arm("R4", 6); sclk_mode = 1'b1;
    wait_mode(M_HOLD, 40, "R4");
    hold_then_ramp(2 * LRP, "R4");
    run_traffic();

    // R5: master clock stops
    @(negedge clk); arm("R5", LOSS + 12); gen_on = 1'b0;
    wait_mode(M_HOLD, LOSS + 60, "R5");
    repeat (300) @(negedge clk);
    gen_on = 1'b1;
    hold_then_ramp(2 * LRP, "R5");
    run_traffic();

    // R8: fault during the ramp restarts it from zero
    @(negedge clk); arm("R4", 6); sclk_mode = 1'b0;
    wait_mode(M_HOLD, 40, "R4");
    repeat (2 * LRP) @(negedge clk);
    first_nz = -1; prev_abs = 0; mode = M_RAMP;
    while (!(first_nz >= 0 && cyc - first_nz >= 2000) && cyc < 180000) @(negedge clk);
    restart_armed = 1'b1; restart_seen = 1'b0;
    sclk_mode = 1'b1;
    repeat (10) @(negedge clk);
    chk(restart_seen, "R8", "outputs back to zero", int'(restart_seen), 1);
    chk(mute == 1'b1, "R8", "still muted after restart", int'(mute), 1);
    wait_mode(M_RUN, 6 * 1536 + RAMP_LEN + 200, "R8");
    chk(ramp_len == RAMP_LEN, "R8", "full ramp after restart", ramp_len, RAMP_LEN);
    run_traffic();
    chk(ramps == 6, "R7", "ramps completed", ramps, 6);
    finish_run();
  end
endmodule